// File: doc/BRIEF.md
# SAR ADC Sampling Sequencer

This block is the digital control core that decides when an external successive-approximation converter samples its input and when it converts. It drives three strobes to the analog side: one that holds the sample switch closed, one that starts the conversion, and one that powers the reference. It receives a single conversion-done input back. After conversion-done it raises a one-cycle data-valid pulse, so the consumer knows when to pick up the result.

Two sampling disciplines are available. In the timed (synchronous) discipline, the core rests idle. A trigger opens a sampling window of 2^N clock cycles, where N is a 4-bit exponent, and the conversion starts when the window closes. In the free-running (asynchronous) discipline, the sample strobe stays high whenever the core is idle. A trigger closes it and starts the conversion at once. In the timed discipline the reference can also be switched off while idle.

The mode, the exponent and the reference-gating option are captured only when the active-low soft reset is released. The core enable and the reference enable act at once. Before it accepts a trigger, the core raises a clock request and waits for the acknowledge.

Top module: `adc_seq_ctrl`

## Requirements
- R1: `clk_req` is high one cycle after `core_en` and `core_rst_n` are both high. While `clk_ack` is low, a trigger is not accepted: `busy`, `sample` and `convert` stay low in timed mode.
- R2: In timed mode (`cfg_async_mode`=0), an idle trigger raises `sample` and `busy` from the next cycle on. `sample` stays high for exactly 2^`cfg_smpl_exp` cycles. `convert` then rises in the cycle in which `sample` falls.
- R3: The exponent covers its full range: a value of 0 gives a 1-cycle window and a value of 15 gives a 32768-cycle window.
- R4: In free-running mode (`cfg_async_mode`=1), `sample` is high while idle. A trigger makes `sample` low and `convert` high in the next cycle.
- R5: `conv_done` during conversion makes `convert` low and `data_valid` high for exactly one cycle. In the same cycle, timed mode leaves `sample` low and free-running mode has `sample` high again.
- R6: A trigger during a sampling window or a conversion is ignored. The window length is unchanged and `convert` stays high.
- R7: `busy` is high during the sampling window and the conversion, and low in idle in timed mode.
- R8: In timed mode with `cfg_ref_idle_off`=1, `ref_on` is low while idle and high during sampling and conversion. With the option at 0, `ref_on` follows `ref_en_req`.
- R9: `cfg_async_mode`, `cfg_smpl_exp` and `cfg_ref_idle_off` take effect only at a low-to-high transition of `core_rst_n`. Changes at other times are ignored.
- R10: `ref_en_req` low forces `ref_on` low in the same cycle. `core_en` low makes `clk_req` low after one clock edge.
- R11: If `clk_ack` or `core_en` drops during operation, the core returns to its off state one edge later, with `sample`, `convert` and `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low hard reset |
| core_rst_n | input | 1 | Active-low soft reset; a rising transition captures the configuration |
| core_en | input | 1 | Core enable, acts immediately |
| ref_en_req | input | 1 | Reference enable, acts immediately |
| cfg_async_mode | input | 1 | 1 = free-running sampling, 0 = timed window |
| cfg_ref_idle_off | input | 1 | Power the reference off while idle in timed mode |
| cfg_smpl_exp | input | 4 | Window length exponent, window = 2^value cycles |
| clk_ack | input | 1 | Clock acknowledge from the clock controller |
| trig | input | 1 | Start trigger |
| conv_done | input | 1 | Conversion finished, from the analog side |
| clk_req | output | 1 | Clock request |
| sample | output | 1 | Sample switch strobe |
| convert | output | 1 | Conversion strobe |
| ref_on | output | 1 | Reference power enable |
| data_valid | output | 1 | One-cycle result strobe |
| busy | output | 1 | Sampling window or conversion in progress |

## Verification
On every cycle, the assertions check three things. First, a missing clock grant always returns the core to off. Second, a trigger in mid-window or mid-conversion leaves the state unchanged, and a free-running trigger goes straight to conversion. Third, the captured configuration only changes at the soft reset edge, the window counter only counts down, and data-valid never lasts longer than one cycle. Some behaviours only the bench scenarios can show, because they depend on end-to-end timing and external sequences. These are the exact window length for each exponent up to 32768 cycles, the reference gating across idle and active phases, and the loss of configuration changes that were not followed by a soft reset.

// File: rtl/adc_seq_pkg.sv
// Package: shared types for the ADC sampling sequencer.
// Assumes: one clock domain; all users import this package.
package adc_seq_pkg;

    // Default exponent width; the window reaches 2^(2^W - 1) cycles.
    localparam int unsigned SEQ_EXP_W = 4;

    // Sequencer states.
    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_IDLE   = 2'd1,
        ST_SAMPLE = 2'd2,
        ST_CONV   = 2'd3
    } seq_state_e;

    // Mode bits captured at the soft reset release.
    typedef struct packed {
        logic async_mode;
        logic ref_idle_off;
    } seq_mode_t;

endpackage

// File: rtl/adc_seq_cfg.sv
// Module: configuration capture.
// Holds the mode bits and window exponent. It loads them only in the
// cycle where the soft reset input rises. Assumes core_rst_n is synchronous.
module adc_seq_cfg
    import adc_seq_pkg::*;
#(
    parameter int unsigned EXP_W = SEQ_EXP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             core_rst_n,
    input  logic             cfg_async_mode,
    input  logic             cfg_ref_idle_off,
    input  logic [EXP_W-1:0] cfg_smpl_exp,
    output seq_mode_t        mode_q,
    output logic [EXP_W-1:0] exp_q
);

    logic core_rst_d;
    logic capture;

    // Soft reset release detection.
    assign capture = core_rst_n && !core_rst_d;

    // Track the previous soft reset level.
    always_ff @(posedge clk) begin
        if (!rst_n) core_rst_d <= 1'b0;
        else        core_rst_d <= core_rst_n;
    end

    // Load the configuration at the release edge only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            exp_q  <= '0;
        end else if (capture) begin
            mode_q.async_mode   <= cfg_async_mode;
            mode_q.ref_idle_off <= cfg_ref_idle_off;
            exp_q               <= cfg_smpl_exp;
        end
    end

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rst_d && core_rst_n) |=> ($stable(mode_q) && $stable(exp_q)));

endmodule

// File: rtl/adc_seq_clkhs.sv
// Module: clock request/acknowledge handshake.
// Raises the request while the core is enabled and out of soft reset.
// Reports ready once the acknowledge matches.
// Assumes clk_ack is already synchronous to clk.
module adc_seq_clkhs (
    input  logic clk,
    input  logic rst_n,
    input  logic core_en,
    input  logic core_rst_n,
    input  logic clk_ack,
    output logic clk_req,
    output logic ready
);

    logic want;

    // Core wants a clock whenever enabled and out of soft reset.
    assign want = core_en && core_rst_n;

    // Registered request toward the clock controller.
    always_ff @(posedge clk) begin
        if (!rst_n) clk_req <= 1'b0;
        else        clk_req <= want;
    end

    // Ready needs the request, its acknowledge, and the live enable.
    assign ready = clk_req && clk_ack && want;

endmodule

// File: rtl/adc_seq_timer.sv
// Module: sampling window timer.
// Loads 2^exp - 1 on a timed trigger and counts down while sampling.
// Flags done at zero, so the window lasts 2^exp cycles.
// Assumes load and run are never high together.
module adc_seq_timer
    import adc_seq_pkg::*;
#(
    parameter int unsigned EXP_W = SEQ_EXP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [EXP_W-1:0] exp_q,
    output logic             done
);

    localparam int unsigned CNT_W = (1 << EXP_W) - 1;

    logic [CNT_W:0]   span;
    logic [CNT_W:0]   span_m1;
    logic [CNT_W-1:0] cnt;

    // Window length as a one-hot value, then minus one.
    assign span    = {{CNT_W{1'b0}}, 1'b1} << exp_q;
    assign span_m1 = span - {{CNT_W{1'b0}}, 1'b1};

    // Countdown register.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= '0;
        else if (load)               cnt <= span_m1[CNT_W-1:0];
        else if (run && cnt != '0)   cnt <= cnt - 1'b1;
    end

    // End of window.
    assign done = run && (cnt == '0);

    // R2
    win_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && cnt != '0) |=> (cnt < $past(cnt)));

endmodule

// File: rtl/adc_seq_fsm.sv
// Module: sampling sequencer state machine.
// Walks through off, idle, sample and convert, and pulses data_valid after
// conversion-done. Assumes ready already includes the clock grant.
module adc_seq_fsm
    import adc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ready,
    input  logic       trig,
    input  logic       async_mode,
    input  logic       win_done,
    input  logic       conv_done,
    output seq_state_e state,
    output logic       win_load,
    output logic       data_valid
);

    // Timed trigger accepted in idle starts the window timer.
    assign win_load = ready && (state == ST_IDLE) && trig && !async_mode;

    // State register and result strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_OFF;
            data_valid <= 1'b0;
        end else begin
            data_valid <= 1'b0;
            if (!ready) begin
                state <= ST_OFF;
            end else begin
                unique case (state)
                    ST_OFF:    state <= ST_IDLE;
                    ST_IDLE:   if (trig) state <= async_mode ? ST_CONV : ST_SAMPLE;
                    ST_SAMPLE: if (win_done) state <= ST_CONV;
                    ST_CONV: begin
                        if (conv_done) begin
                            state      <= ST_IDLE;
                            data_valid <= 1'b1;
                        end
                    end
                    default:   state <= ST_OFF;
                endcase
            end
        end
    end

    // R1
    no_grant_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> (state == ST_OFF));

    // R5
    dv_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |=> !data_valid);

    // R6
    trig_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && trig && state == ST_SAMPLE && !win_done) |=> (state == ST_SAMPLE));

    // R4
    async_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && trig && async_mode && state == ST_IDLE) |=> (state == ST_CONV));

endmodule

// File: rtl/adc_seq_ctrl.sv
// Module: top of the SAR ADC sampling sequencer.
// Joins configuration capture, the clock handshake, the window timer and
// the state machine, and decodes the analog-side strobes from the state.
// Assumes all inputs are synchronous to clk.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int unsigned EXP_W = SEQ_EXP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             core_rst_n,
    input  logic             core_en,
    input  logic             ref_en_req,
    input  logic             cfg_async_mode,
    input  logic             cfg_ref_idle_off,
    input  logic [EXP_W-1:0] cfg_smpl_exp,
    input  logic             clk_ack,
    input  logic             trig,
    input  logic             conv_done,
    output logic             clk_req,
    output logic             sample,
    output logic             convert,
    output logic             ref_on,
    output logic             data_valid,
    output logic             busy
);

    seq_mode_t        mode_q;
    logic [EXP_W-1:0] exp_q;
    logic             ready;
    logic             win_load;
    logic             win_done;
    seq_state_e       state;
    logic             in_window;
    logic             ref_gated;

    adc_seq_cfg #(.EXP_W(EXP_W)) u_cfg (
        .clk              (clk),
        .rst_n            (rst_n),
        .core_rst_n       (core_rst_n),
        .cfg_async_mode   (cfg_async_mode),
        .cfg_ref_idle_off (cfg_ref_idle_off),
        .cfg_smpl_exp     (cfg_smpl_exp),
        .mode_q           (mode_q),
        .exp_q            (exp_q)
    );

    adc_seq_clkhs u_clkhs (
        .clk        (clk),
        .rst_n      (rst_n),
        .core_en    (core_en),
        .core_rst_n (core_rst_n),
        .clk_ack    (clk_ack),
        .clk_req    (clk_req),
        .ready      (ready)
    );

    adc_seq_timer #(.EXP_W(EXP_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (win_load),
        .run   (in_window),
        .exp_q (exp_q),
        .done  (win_done)
    );

    adc_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ready      (ready),
        .trig       (trig),
        .async_mode (mode_q.async_mode),
        .win_done   (win_done),
        .conv_done  (conv_done),
        .state      (state),
        .win_load   (win_load),
        .data_valid (data_valid)
    );

    // Timed window in progress.
    assign in_window = (state == ST_SAMPLE);

    // Strobe decode: the free-running mode samples whenever idle.
    assign sample  = in_window || (state == ST_IDLE && mode_q.async_mode);
    assign convert = (state == ST_CONV);
    assign busy    = in_window || convert;

    // Reference is gated outside activity only in timed mode with the option set.
    assign ref_gated = !mode_q.async_mode && mode_q.ref_idle_off && !busy;
    assign ref_on    = ref_en_req && !ref_gated;

    // R8
    ref_during_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_window && ref_en_req) |-> ref_on);

endmodule

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       core_rst_n = 1'b0;
    logic       core_en = 1'b0;
    logic       ref_en_req = 1'b1;
    logic       cfg_async_mode = 1'b0;
    logic       cfg_ref_idle_off = 1'b0;
    logic [3:0] cfg_smpl_exp = 4'd0;
    logic       clk_ack = 1'b0;
    logic       trig = 1'b0;
    logic       conv_done = 1'b0;
    logic       clk_req, sample, convert, ref_on, data_valid, busy;

    logic ack_en = 1'b1;
    int   n_chk = 0;
    int   n_bad = 0;
    int   exp_q[$];
    int   run_len = 0;
    logic prev_conv = 1'b0;
    bit   finished = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    adc_seq_ctrl i_adc_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .core_rst_n(core_rst_n), .core_en(core_en),
        .ref_en_req(ref_en_req), .cfg_async_mode(cfg_async_mode),
        .cfg_ref_idle_off(cfg_ref_idle_off), .cfg_smpl_exp(cfg_smpl_exp),
        .clk_ack(clk_ack), .trig(trig), .conv_done(conv_done),
        .clk_req(clk_req), .sample(sample), .convert(convert), .ref_on(ref_on),
        .data_valid(data_valid), .busy(busy)
    );

    // Clock controller model: acknowledge follows the request one cycle later.
    always @(posedge clk) clk_ack <= ack_en & clk_req;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, expv, $time);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Monitor: compares each measured sampling run with the scoreboard entry.
    always @(negedge clk) begin
        if (rst_n && convert && !prev_conv) begin
            if (exp_q.size() == 0) begin
                chk(0, "R2 unexpected conversion", 1, 0);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (e >= 0) chk(run_len == e, "R2/R3 window length", run_len, e);
            end
        end
        prev_conv = convert;
        run_len   = sample ? run_len + 1 : 0;
    end

    task automatic soft_reset(input bit am, input bit ro, input int e);
        cfg_async_mode = am; cfg_ref_idle_off = ro; cfg_smpl_exp = 4'(e);
        core_rst_n = 1'b0;
        tick(2);
        core_rst_n = 1'b1;
        tick(6);
    endtask

    // Driver: one timed conversion; pushes the expected window length.
    task automatic do_sync(input int len, input bit spam, input bit gated);
        trig = 1'b1;
        exp_q.push_back(len);
        tick();
        trig = 1'b0;
        chk(sample == 1'b1 && busy == 1'b1, "R7 busy/sample in window", {sample, busy}, 3);
        if (gated) chk(ref_on == 1'b1, "R8 ref on while sampling", ref_on, 1);
        if (spam && len >= 4) begin
            trig = 1'b1; tick(); trig = 1'b0;
        end
        for (int n = 0; n < 40000 && !convert; n++) tick();
        chk(busy == 1'b1 && convert == 1'b1, "R7 busy during conversion", busy, 1);
        if (gated) chk(ref_on == 1'b1, "R8 ref on while converting", ref_on, 1);
        if (spam) begin
            trig = 1'b1; tick(); trig = 1'b0;
            chk(convert == 1'b1, "R6 trigger ignored in conversion", convert, 1);
        end
        tick();
        conv_done = 1'b1; tick(); conv_done = 1'b0;
        chk(data_valid == 1'b1 && convert == 1'b0, "R5 result strobe", {data_valid, convert}, 2);
        chk(sample == 1'b0 && busy == 1'b0, "R7 idle after timed conversion", {sample, busy}, 0);
        if (gated) chk(ref_on == 1'b0, "R8 ref off in idle", ref_on, 0);
        tick();
        chk(data_valid == 1'b0, "R5 strobe lasts one cycle", data_valid, 0);
    endtask

    // Driver: one free-running conversion.
    task automatic do_async;
        chk(sample == 1'b1, "R4 sampling while idle", sample, 1);
        trig = 1'b1;
        exp_q.push_back(-1);
        tick();
        trig = 1'b0;
        chk(sample == 1'b0 && convert == 1'b1, "R4 trigger starts conversion", {sample, convert}, 1);
        tick(2);
        conv_done = 1'b1; tick(); conv_done = 1'b0;
        chk(data_valid == 1'b1 && sample == 1'b1, "R5 sampling resumes", {data_valid, sample}, 3);
        tick();
        chk(data_valid == 1'b0, "R5 strobe lasts one cycle", data_valid, 0);
    endtask

    initial begin
        #(8 * 200000);
        chk(0, "watchdog expired", 0, 1);
        if (!finished) report();
    end

    initial begin
        tick(3);
        chk(clk_req == 0 && sample == 0 && convert == 0 && busy == 0 && data_valid == 0,
            "R1 reset state", {clk_req, sample, convert, busy, data_valid}, 0);
        rst_n = 1'b1;
        core_en = 1'b1;
        ack_en = 1'b0;
        soft_reset(0, 0, 2);
        chk(clk_req == 1'b1, "R1 clock request raised", clk_req, 1);
        trig = 1'b1; tick(); trig = 1'b0;
        chk(busy == 0 && sample == 0, "R1 trigger refused without ack", {busy, sample}, 0);
        tick(3);
        chk(busy == 0 && convert == 0, "R1 still refused", {busy, convert}, 0);
        ack_en = 1'b1;
        tick(4);

        // Timed windows
        chk(ref_on == 1'b1, "R8 ref follows request when not gated", ref_on, 1);
        do_sync(4, 0, 0);
        do_sync(4, 1, 0);                       // R6
        soft_reset(0, 0, 0);
        do_sync(1, 0, 0);                       // R3 shortest
        soft_reset(0, 0, 5);
        do_sync(32, 1, 0);
        soft_reset(0, 0, 15);
        do_sync(32768, 0, 0);                   // R3 longest

        // R9: inputs changed without soft reset are ignored
        soft_reset(0, 0, 3);
        cfg_smpl_exp = 4'd7; cfg_async_mode = 1'b1; cfg_ref_idle_off = 1'b1;
        tick(3);
        chk(sample == 1'b0 && ref_on == 1'b1, "R9 mode change ignored", {sample, ref_on}, 1);
        do_sync(8, 0, 0);

        // R8: reference gating in timed mode
        soft_reset(0, 1, 1);
        chk(ref_on == 1'b0, "R8 ref off while idle", ref_on, 0);
        do_sync(2, 0, 1);
        trig = 1'b1; exp_q.push_back(2); tick(); trig = 1'b0;
        ref_en_req = 1'b0; #1;
        chk(ref_on == 1'b0, "R10 ref request acts at once", ref_on, 0);
        ref_en_req = 1'b1; #1;
        chk(ref_on == 1'b1, "R10 ref request restored", ref_on, 1);
        for (int n = 0; n < 10 && !convert; n++) tick();
        conv_done = 1'b1; tick(); conv_done = 1'b0;
        tick();

        // R11: enable dropped during a window
        soft_reset(0, 0, 4);
        trig = 1'b1; tick(); trig = 1'b0;
        tick(2);
        core_en = 1'b0; tick();
        chk(sample == 0 && busy == 0 && convert == 0, "R11 abort on enable loss", {sample, busy}, 0);
        chk(clk_req == 1'b0, "R10 request drops with enable", clk_req, 0);
        core_en = 1'b1;
        tick(5);

        // Free-running mode
        soft_reset(1, 1, 9);
        chk(ref_on == 1'b1, "R8 no gating in free-running mode", ref_on, 1);
        do_async();
        tick(5);
        do_async();
        ack_en = 1'b0;
        tick(2);
        chk(sample == 1'b0 && busy == 1'b0, "R11 off when ack drops", {sample, busy}, 0);
        ack_en = 1'b1;
        tick(4);
        chk(sample == 1'b1, "R11 resumes after ack returns", sample, 1);

        tick(3);
        chk(exp_q.size() == 0, "R2 all expected conversions seen", exp_q.size(), 0);
        finished = 1'b1;
        report();
    end

endmodule